// File: doc/BRIEF.md
# Wrapping Word-Address Pointer with Region Read Mux

This block keeps the single word-address pointer of a serial nonvolatile memory slave and turns it into the byte that the protocol engine shifts out on a read. The engine loads the pointer from the two word-address bytes of a command, then pulses a step strobe after every data byte. The pointer therefore always rests on the last byte touched plus one, which is where a following current-address read begins.

Three wrap rules apply. A write step moves only the in-page offset, so the pointer circles within one 32-byte page. A read step in the main array crosses pages and rolls from the top of the 8192-byte array to zero. A read step in the identification region circles within that 32-byte region. The array and the region share one pointer, and nothing clears it when the region select changes.

The read byte comes from one of three places. With the region select low it is the array byte at the pointer. With the select high and the pointer's two region-key bits correct, the first 16 offsets give the bytes of a 128-bit identifier held as a parameter, and the next 16 give zero. With a wrong key the byte is a fixed fill value. Bus timing and the commit of writes to storage belong to other blocks.

Top module: `wordptr_region_mux`

## Requirements
- R1: While rst_n is low the pointer is cleared, so mem_addr reads 0 on the first clock after reset.
- R2: A load_hi pulse copies load_byte[4:0] into pointer bits [12:8]; load_byte[7:5] are ignored. A load_lo pulse copies load_byte into bits [7:0]. Each takes effect on the next mem_addr.
- R3: A step with wr_mode=1 adds one to pointer bits [4:0] modulo 32 and leaves bits [12:5] unchanged, so offset 31 goes to offset 0 of the same page.
- R4: A step with wr_mode=0 and id_region=0 adds one to the full 13-bit pointer, and 8191 goes to 0.
- R5: A step with wr_mode=0 and id_region=1 adds one to bits [4:0] modulo 32 and leaves bits [12:5] unchanged.
- R6: With id_region=0, rd_byte equals mem_rdata in the same cycle, and mem_rdata is the array byte at mem_addr.
- R7: With id_region=1, pointer bits [11:10]=2'b10 and bits [4:0] below 16, rd_byte is identifier byte n, where n is bits [3:0] and byte 0 is the most significant byte of ID_VALUE. Bit 12 is ignored.
- R8: With id_region=1, bits [11:10]=2'b10 and bits [4:0] in 16..31, rd_byte is 8'h00.
- R9: With id_region=1 and bits [11:10] not 2'b10, rd_byte is 8'hFF.
- R10: The pointer holds whenever no strobe is pulsed, whatever wr_mode and id_region do. A load pulsed together with step wins over the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_hi | input | 1 | Load upper pointer bits from load_byte |
| load_lo | input | 1 | Load lower pointer byte from load_byte |
| load_byte | input | 8 | Word-address byte received by the engine |
| step | input | 1 | Advance the pointer after a data byte |
| wr_mode | input | 1 | 1 while the current transfer is a write |
| id_region | input | 1 | 1 while the identification region is addressed |
| mem_rdata | input | 8 | Array byte at mem_addr |
| mem_addr | output | 13 | Pointer value, the array address |
| rd_byte | output | 8 | Byte to be shifted out |

## Verification
The step properties assume that a step arrives without a load in the same cycle; the bench tests the overlapping case on its own, through the ports. The pass-through and fill properties assume that mem_rdata is a combinational function of mem_addr with no read latency. The bench models the array that way, from a fixed function of the address. The bench changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. It keeps wr_mode and id_region steady between a step and the sample that checks it, so every region decode is observed against a settled pointer.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

   typedef enum logic [1:0] {
      WRAP_FULL   = 2'd0,
      WRAP_PAGE   = 2'd1,
      WRAP_REGION = 2'd2
   } wrap_e;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_IDBYTE = 2'd1,
      SRC_ZERO   = 2'd2,
      SRC_FILL   = 2'd3
   } rd_src_e;

   function automatic wrap_e pick_wrap(input logic wr, input logic idr);
      if (wr)       return WRAP_PAGE;
      else if (idr) return WRAP_REGION;
      else          return WRAP_FULL;
   endfunction

endpackage

// File: rtl/wpr_pointer.sv
module wpr_pointer
   import wpr_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 5,
   parameter int OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_hi,
   input  logic              load_lo,
   input  logic [DATA_W-1:0] load_byte,
   input  logic              step,
   input  logic              wr_mode,
   input  logic              id_region,
   output logic [ADDR_W-1:0] ptr
);
   localparam int HI_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_W) - 64'd1);
   localparam logic [ADDR_W-1:0] REG_MASK  = ADDR_W'((64'd1 << OFS_W) - 64'd1);
   localparam logic [ADDR_W-1:0] FULL_MASK = {ADDR_W{1'b1}};

   initial begin
      assert (HI_W > 0 && HI_W <= DATA_W) else $fatal(1, "pointer must span one to two load bytes");
      assert (PAGE_W > 0 && PAGE_W < ADDR_W) else $fatal(1, "page width out of range");
      assert (OFS_W > 0 && OFS_W < ADDR_W) else $fatal(1, "region offset width out of range");
   end

   wrap_e             mode;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] bumped;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] nxt;

   assign mode   = pick_wrap(wr_mode, id_region);
   assign bumped = ptr + {{(ADDR_W-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (mode)
         WRAP_PAGE:   mask = PAGE_MASK;
         WRAP_REGION: mask = REG_MASK;
         default:     mask = FULL_MASK;
      endcase
   end

   // one shared adder; the mask decides which bits may move
   assign stepped = (ptr & ~mask) | (bumped & mask);

   always_comb begin
      nxt = ptr;
      if (load_hi) nxt[ADDR_W-1:DATA_W] = load_byte[HI_W-1:0];
      if (load_lo) nxt[DATA_W-1:0]      = load_byte;
      if (!load_hi && !load_lo && step) nxt = stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= nxt;
   end

endmodule

// File: rtl/wpr_id_rom.sv
module wpr_id_rom #(
   parameter int DATA_W   = 8,
   parameter int ID_BYTES = 16,
   parameter logic [ID_BYTES*DATA_W-1:0] ID_VALUE = '0
) (
   input  logic [$clog2(ID_BYTES)-1:0] id_idx,
   output logic [DATA_W-1:0]           id_byte
);
   localparam int IDX_W = $clog2(ID_BYTES);

   initial begin
      assert (ID_BYTES >= 2 && ID_BYTES == (1 << IDX_W))
         else $fatal(1, "identifier length must be a power of two");
   end

   logic [DATA_W-1:0] rom [ID_BYTES];

   // byte 0 is the most significant byte of the parameter
   for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
      assign rom[g] = ID_VALUE[(ID_BYTES-1-g)*DATA_W +: DATA_W];
   end

   assign id_byte = rom[id_idx];

endmodule

// File: rtl/wpr_data_sel.sv
module wpr_data_sel
   import wpr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 2,
   parameter logic [SEL_W-1:0] SEL_MATCH = 2'b10,
   parameter int OFS_W    = 5,
   parameter int ID_BYTES = 16,
   parameter logic [DATA_W-1:0] UNDEF_FILL = 8'hFF
) (
   input  logic                        id_region,
   input  logic [SEL_W-1:0]            sel_field,
   input  logic [OFS_W-1:0]            ofs,
   input  logic [DATA_W-1:0]           mem_rdata,
   input  logic [DATA_W-1:0]           id_byte,
   output logic [$clog2(ID_BYTES)-1:0] id_idx,
   output logic [DATA_W-1:0]           sel_byte
);
   localparam int IDX_W = $clog2(ID_BYTES);

   initial begin
      assert (IDX_W <= OFS_W) else $fatal(1, "identifier longer than region");
   end

   rd_src_e src;
   logic    in_id;

   assign id_idx = ofs[IDX_W-1:0];
   assign in_id  = ({1'b0, ofs} < (OFS_W+1)'(ID_BYTES));

   always_comb begin
      if (!id_region)              src = SRC_ARRAY;
      else if (sel_field != SEL_MATCH) src = SRC_FILL;
      else if (in_id)              src = SRC_IDBYTE;
      else                         src = SRC_ZERO;
   end

   always_comb begin
      unique case (src)
         SRC_ARRAY:  sel_byte = mem_rdata;
         SRC_IDBYTE: sel_byte = id_byte;
         SRC_ZERO:   sel_byte = '0;
         default:    sel_byte = UNDEF_FILL;
      endcase
   end

endmodule

// File: rtl/wordptr_region_mux.sv
module wordptr_region_mux #(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 5,
   parameter int OFS_W    = 5,
   parameter int SEL_LSB  = 10,
   parameter int SEL_W    = 2,
   parameter logic [SEL_W-1:0] SEL_MATCH = 2'b10,
   parameter int ID_BYTES = 16,
   parameter logic [ID_BYTES*DATA_W-1:0] ID_VALUE = 128'h5E_11_A7_03_9C_42_D8_6B_F0_17_2A_C5_88_3D_E9_64,
   parameter logic [DATA_W-1:0] UNDEF_FILL = 8'hFF,
   parameter int OUT_REG  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_hi,
   input  logic              load_lo,
   input  logic [7:0]        load_byte,
   input  logic              step,
   input  logic              wr_mode,
   input  logic              id_region,
   input  logic [7:0]        mem_rdata,
   output logic [12:0]       mem_addr,
   output logic [7:0]        rd_byte
);
   localparam int IDX_W = $clog2(ID_BYTES);

   initial begin
      assert (ADDR_W == 13 && DATA_W == 8) else $fatal(1, "port widths fixed at 13 and 8");
      assert (SEL_LSB >= OFS_W && SEL_LSB + SEL_W <= ADDR_W)
         else $fatal(1, "region key field overlaps offset or exceeds pointer");
      assert (OUT_REG == 0 || OUT_REG == 1) else $fatal(1, "OUT_REG is 0 or 1");
   end

   logic [ADDR_W-1:0] ptr;
   logic [IDX_W-1:0]  id_idx;
   logic [DATA_W-1:0] id_byte;
   logic [DATA_W-1:0] sel_byte;

   wpr_pointer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)
   ) u_pointer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_hi   (load_hi),
      .load_lo   (load_lo),
      .load_byte (load_byte),
      .step      (step),
      .wr_mode   (wr_mode),
      .id_region (id_region),
      .ptr       (ptr)
   );

   wpr_id_rom #(
      .DATA_W(DATA_W), .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)
   ) u_id_rom (
      .id_idx  (id_idx),
      .id_byte (id_byte)
   );

   wpr_data_sel #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_MATCH(SEL_MATCH),
      .OFS_W(OFS_W), .ID_BYTES(ID_BYTES), .UNDEF_FILL(UNDEF_FILL)
   ) u_data_sel (
      .id_region (id_region),
      .sel_field (ptr[SEL_LSB+SEL_W-1:SEL_LSB]),
      .ofs       (ptr[OFS_W-1:0]),
      .mem_rdata (mem_rdata),
      .id_byte   (id_byte),
      .id_idx    (id_idx),
      .sel_byte  (sel_byte)
   );

   assign mem_addr = ptr;

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_byte <= '0;
         else        rd_byte <= sel_byte;
      end
   end else begin : g_out_comb
      assign rd_byte = sel_byte;
   end

endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 5,
   parameter int OFS_W    = 5,
   parameter int SEL_LSB  = 10,
   parameter int SEL_W    = 2,
   parameter logic [SEL_W-1:0] SEL_MATCH = 2'b10,
   parameter int ID_BYTES = 16,
   parameter logic [DATA_W-1:0] UNDEF_FILL = 8'hFF,
   parameter int OUT_REG  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_hi,
   input logic              load_lo,
   input logic [DATA_W-1:0] load_byte,
   input logic              step,
   input logic              wr_mode,
   input logic              id_region,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] rd_byte
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic only_step;
   assign only_step = step && !load_hi && !load_lo;

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (mem_addr == '0));

   a_r2_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load_hi && !load_lo) |=>
         (mem_addr[ADDR_W-1:DATA_W] == $past(load_byte[HI_W-1:0])) &&
         (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0])));

   a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load_lo && !load_hi) |=>
         (mem_addr[DATA_W-1:0] == $past(load_byte)) &&
         $stable(mem_addr[ADDR_W-1:DATA_W]));

   a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && wr_mode) |=>
         $stable(mem_addr[ADDR_W-1:PAGE_W]) &&
         (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1)));

   a_r4_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && !wr_mode && !id_region) |=>
         (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   a_r5_region_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && !wr_mode && id_region) |=>
         $stable(mem_addr[ADDR_W-1:OFS_W]) &&
         (mem_addr[OFS_W-1:0] == OFS_W'($past(mem_addr[OFS_W-1:0]) + 1'b1)));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load_hi && !load_lo) |=> $stable(mem_addr));

   if (OUT_REG == 0) begin : g_comb_checks
      a_r6_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
         !id_region |-> (rd_byte == mem_rdata));

      a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
         (id_region && mem_addr[SEL_LSB+SEL_W-1:SEL_LSB] == SEL_MATCH &&
          {1'b0, mem_addr[OFS_W-1:0]} >= (OFS_W+1)'(ID_BYTES)) |-> (rd_byte == '0));

      a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
         (id_region && mem_addr[SEL_LSB+SEL_W-1:SEL_LSB] != SEL_MATCH) |->
            (rd_byte == UNDEF_FILL));
   end

endmodule

bind wordptr_region_mux wpr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W),
   .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .SEL_MATCH(SEL_MATCH),
   .ID_BYTES(ID_BYTES), .UNDEF_FILL(UNDEF_FILL), .OUT_REG(OUT_REG)
) u_wpr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_hi   (load_hi),
   .load_lo   (load_lo),
   .load_byte (load_byte),
   .step      (step),
   .wr_mode   (wr_mode),
   .id_region (id_region),
   .mem_rdata (mem_rdata),
   .mem_addr  (mem_addr),
   .rd_byte   (rd_byte)
);

// File: tb/wordptr_region_mux_bench.sv
module wordptr_region_mux_bench;
   localparam int CLK_P = 10;
   localparam logic [127:0] BENCH_ID = 128'hA1B2C3D4E5F60718293A4B5C6D7E8F90;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_hi = 1'b0, load_lo = 1'b0, step = 1'b0;
   logic        wr_mode = 1'b0, id_region = 1'b0;
   logic [7:0]  load_byte = 8'h00;
   logic [7:0]  mem_rdata;
   logic [12:0] mem_addr;
   logic [7:0]  rd_byte;

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] arr_model(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction

   assign mem_rdata = arr_model(mem_addr);

   wordptr_region_mux #(.ID_VALUE(BENCH_ID)) u_wordptr_region_mux (
      .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
      .load_byte(load_byte), .step(step), .wr_mode(wr_mode),
      .id_region(id_region), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .rd_byte(rd_byte)
   );

   typedef struct {
      string       req;
      logic [12:0] addr;
      logic [7:0]  data;
   } exp_t;

   exp_t        sb_q[$];
   int          checks = 0;
   int          errors = 0;
   logic [12:0] m_ptr = '0;
   logic        m_idr = 1'b0;
   bit          done = 1'b0;

   // expected read byte from the requirements
   function automatic logic [7:0] exp_byte(input logic [12:0] a, input logic idr);
      if (!idr)              return arr_model(a);          // R6
      if (a[11:10] != 2'b10) return 8'hFF;                 // R9
      if (a[4])              return 8'h00;                 // R8
      return BENCH_ID[127 - 8*int'(a[3:0]) -: 8];          // R7
   endfunction

   task automatic push(input string req);
      exp_t e;
      e.req  = req;
      e.addr = m_ptr;
      e.data = exp_byte(m_ptr, m_idr);
      sb_q.push_back(e);
   endtask

   // driver: called on a falling edge, returns on a falling edge two cycles later
   task automatic op(input bit lh, input bit ll, input bit st, input logic [7:0] b,
                     input bit wr, input bit idr, input string req);
      load_hi = lh; load_lo = ll; step = st; load_byte = b;
      wr_mode = wr; id_region = idr; m_idr = idr;
      if (lh) m_ptr[12:8] = b[4:0];
      if (ll) m_ptr[7:0]  = b;
      if (!lh && !ll && st) begin
         if (wr || idr) m_ptr[4:0] = m_ptr[4:0] + 5'd1;
         else           m_ptr      = m_ptr + 13'd1;
      end
      @(negedge clk);
      load_hi = 1'b0; load_lo = 1'b0; step = 1'b0;
      push(req);
      @(negedge clk);
   endtask

   task automatic load_ptr(input logic [12:0] a, input bit idr, input string req);
      op(1'b1, 1'b0, 1'b0, {3'b000, a[12:8]}, 1'b0, idr, req);
      op(1'b0, 1'b1, 1'b0, a[7:0], 1'b0, idr, req);
   endtask

   // monitor: compares each expected item against the ports
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (mem_addr !== e.addr) begin
               errors++;
               $display("FAIL %s mem_addr actual=%h expected=%h", e.req, mem_addr, e.addr);
            end
            checks++;
            if (rd_byte !== e.data) begin
               errors++;
               $display("FAIL %s rd_byte actual=%h expected=%h (addr %h)", e.req, rd_byte, e.data, e.addr);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push("R1");                                   // pointer cleared by reset
      @(negedge clk);

      // R2: upper load ignores load_byte[7:5]
      op(1'b1, 1'b0, 1'b0, 8'hE3, 1'b0, 1'b0, "R2");
      op(1'b0, 1'b1, 1'b0, 8'h1E, 1'b0, 1'b0, "R2");

      // R3: write steps wrap inside the page 0x0300..0x031F
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R3");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R3");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R3");

      // R4: array read steps cross the top of the array
      load_ptr(13'h1FFE, 1'b0, "R2");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
      load_ptr(13'h041F, 1'b0, "R6");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");

      // R10: no strobe, flags toggle, pointer holds
      op(1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, "R10");
      op(1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, "R10");

      // R7 / R8 / R5: full walk of the identification region and back
      load_ptr(13'h0800, 1'b1, "R7");
      for (int i = 1; i <= 32; i++) begin
         op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, ((i % 32) < 16) ? "R7" : "R8");
      end

      // R5: region step keeps bits above the offset
      load_ptr(13'h0BFF, 1'b1, "R8");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, "R5");

      // R7: bit 12 ignored by the key
      load_ptr(13'h1805, 1'b1, "R7");

      // R9: wrong key values give fill
      load_ptr(13'h0C05, 1'b1, "R9");
      load_ptr(13'h0405, 1'b1, "R9");
      load_ptr(13'h0003, 1'b1, "R9");

      // R10: current-address read of region after array read uses the left value
      load_ptr(13'h0A0E, 1'b0, "R6");
      op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
      op(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R10");

      // R10: load wins over a simultaneous step
      op(1'b0, 1'b1, 1'b1, 8'h40, 1'b0, 1'b0, "R10");
      op(1'b1, 1'b0, 1'b1, 8'h12, 1'b1, 1'b0, "R10");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule